// File: doc/BRIEF.md
# Bridge Control Register File

A bank of 28 thirty-two-bit words that a host bridge exposes on a word-wide memory-mapped bus. It holds power-on and general configuration, I/O and memory timing, the configuration-map word, GPIO data and enable, interrupt steering, edge and polarity masks, four mailboxes, cache-control words and CPU/memory sizing words. Software reaches every word through byte offsets 0x00 to 0x6C.

The interrupt-enable word is never written directly. Software sets bits through a set alias and clears them through a clear alias. Each alias also keeps the last value written to it. The enable word and the interrupt status word are read-only on the bus. When software raises the soft-reset bit of the general-config word from 0 to 1, the block sends the system a one-cycle reset request. The edge mask, polarity mask and configuration-map word go straight out to neighbouring blocks.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset the words at these byte offsets hold: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word resets to 0, and softResetReq is 0.
- R2: A read strobe `busRd` makes `rdValid` high for exactly the next cycle, with `rdData` set to the addressed word. A plain read/write word returns the last value written to it.
- R3: A write to offset 0x30 stores the value at 0x30 and ORs it into the enable word at 0x38.
- R4: A write to offset 0x34 stores the value at 0x34 and clears every enable bit that is 1 in the value.
- R5: Writes to 0x38 (enable) and 0x3C (interrupt status) have no effect. The status word always reads 0.
- R6: A write to 0x04 that sets bit 2 while the stored bit 2 is 0 raises `softResetReq` for exactly the following cycle. No other write raises it. The written value is stored in every case.
- R7: Writes at byte offsets 0x70 and above are dropped, and reads there return 0.
- R8: An access whose address bits [1:0] are not 00 is not a full-word access. Such a write is dropped and such a read returns 0.
- R9: `irqEdgeMask`, `irqPolMask` and `cfgMapWord` always show the words at 0x24, 0x2C and 0x18. A write appears on them in the cycle after the write.
- R10: A read and a write to the same word in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 7 | Byte address of the access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, registered |
| rdValid | output | 1 | rdData is valid this cycle |
| softResetReq | output | 1 | One-cycle system reset request |
| irqEdgeMask | output | 32 | Interrupt edge-select mask |
| irqPolMask | output | 32 | Interrupt polarity mask |
| cfgMapWord | output | 32 | Configuration-map word |

## Verification
The bound checker checks on every cycle that the set and clear aliases change the enable word by exactly an OR or an AND-NOT with the write data, and that writes to the read-only addresses leave it unchanged. It also checks that every reset request traces back to a qualifying write and lasts one cycle, that unmapped and misaligned reads return 0, and that the three exported words follow their writes. Only the bench's scenarios can show the reset contents of every word, that dropped writes leave all stored words untouched, that a 0-to-1 soft-reset edge is needed rather than a written 1, and that a read colliding with a write sees the old value.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int WORD_COUNT = 28;
  localparam int IDX_W = $clog2(WORD_COUNT);

  localparam int IDX_GENCFG = 1;
  localparam int IDX_CFGMAP = 6;
  localparam int IDX_EDGE   = 9;
  localparam int IDX_POL    = 11;
  localparam int IDX_EN_SET = 12;
  localparam int IDX_EN_CLR = 13;
  localparam int IDX_EN     = 14;
  localparam int IDX_STATUS = 15;

  localparam int SOFT_RST_BIT = 2;

  // strobes from the decoder to the storage
  typedef struct packed {
    logic             store;
    logic             enSet;
    logic             enClr;
    logic             rdReq;
    logic             rdHit;
    logic [IDX_W-1:0] idx;
  } bcr_strobe_t;

  function automatic logic [31:0] resetWord(int i);
    case (i)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output bcr_strobe_t       strobe
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;
  logic              inMap;
  logic              validAcc;
  logic [IDX_W-1:0]  idx;

  assign wordIdx  = busAddr[ADDR_W-1:2];
  assign aligned  = (busAddr[1:0] == 2'b00);
  assign inMap    = (int'(wordIdx) < WORD_COUNT);
  assign validAcc = aligned && inMap;
  assign idx      = wordIdx[IDX_W-1:0];

  always_comb begin
    strobe       = '0;
    strobe.idx   = idx;
    strobe.rdReq = busRd;
    strobe.rdHit = busRd && validAcc;
    if (busWr && validAcc) begin
      // the enable and status words are read-only on the bus
      strobe.store = (int'(idx) != IDX_EN) && (int'(idx) != IDX_STATUS);
      strobe.enSet = (int'(idx) == IDX_EN_SET);
      strobe.enClr = (int'(idx) == IDX_EN_CLR);
    end
  end
endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcr_strobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              softResetReq,
  output logic [DATA_W-1:0] irqEdgeMask,
  output logic [DATA_W-1:0] irqPolMask,
  output logic [DATA_W-1:0] cfgMapWord,
  output logic [DATA_W-1:0] enWord
);
  logic [DATA_W-1:0] words [WORD_COUNT];

  for (genvar g = 0; g < WORD_COUNT; g++) begin : gWord
    if (g == IDX_STATUS) begin : gStatus
      assign words[g] = '0;
    end else if (g == IDX_EN) begin : gEnable
      logic [DATA_W-1:0] wordQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wordQ <= DATA_W'(resetWord(g));
        end else if (strobe.enSet) begin
          wordQ <= wordQ | busWdata;
        end else if (strobe.enClr) begin
          wordQ <= wordQ & ~busWdata;
        end
      end
      assign words[g] = wordQ;
    end else begin : gPlain
      logic [DATA_W-1:0] wordQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wordQ <= DATA_W'(resetWord(g));
        end else if (strobe.store && (int'(strobe.idx) == g)) begin
          wordQ <= busWdata;
        end
      end
      assign words[g] = wordQ;
    end
  end

  logic softEdge;
  assign softEdge = strobe.store && (int'(strobe.idx) == IDX_GENCFG)
                    && !words[IDX_GENCFG][SOFT_RST_BIT] && busWdata[SOFT_RST_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData       <= '0;
      rdValid      <= 1'b0;
      softResetReq <= 1'b0;
    end else begin
      rdValid      <= strobe.rdReq;
      softResetReq <= softEdge;
      if (strobe.rdReq) begin
        rdData <= strobe.rdHit ? words[strobe.idx] : '0;
      end
    end
  end

  assign irqEdgeMask = words[IDX_EDGE];
  assign irqPolMask  = words[IDX_POL];
  assign cfgMapWord  = words[IDX_CFGMAP];
  assign enWord      = words[IDX_EN];
endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              softResetReq,
  output logic [DATA_W-1:0] irqEdgeMask,
  output logic [DATA_W-1:0] irqPolMask,
  output logic [DATA_W-1:0] cfgMapWord
);
  bcr_strobe_t       strobe;
  logic [DATA_W-1:0] enWord;

  bcr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr),
    .busWr  (busWr),
    .busRd  (busRd),
    .strobe (strobe)
  );

  bcr_datapath #(.DATA_W(DATA_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .busWdata    (busWdata),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .softResetReq(softResetReq),
    .irqEdgeMask (irqEdgeMask),
    .irqPolMask  (irqPolMask),
    .cfgMapWord  (cfgMapWord),
    .enWord      (enWord)
  );
endmodule

// File: rtl/bridge_ctrl_regs_chk.sv
module bridge_ctrl_regs_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] rdData,
  input logic              rdValid,
  input logic              softResetReq,
  input logic [DATA_W-1:0] irqEdgeMask,
  input logic [DATA_W-1:0] irqPolMask,
  input logic [DATA_W-1:0] cfgMapWord,
  input logic [DATA_W-1:0] enWord
);
  a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!rstN)
    busRd |=> rdValid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> !rdValid);
  a_r3_set_ors_enable: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(7'h30)) |=> enWord == ($past(enWord) | $past(busWdata)));
  a_r4_clr_masks_enable: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(7'h34)) |=> enWord == ($past(enWord) & ~$past(busWdata)));
  a_r5_enable_read_only: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_W'(7'h38) || busAddr == ADDR_W'(7'h3C))) |=> $stable(enWord));
  a_r6_pulse_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    softResetReq |-> $past(busWr && busAddr == ADDR_W'(7'h04) && busWdata[2]));
  a_r6_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    softResetReq |=> !softResetReq);
  a_r7_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr >= ADDR_W'(7'h70)) |=> rdData == '0);
  a_r8_misaligned_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[1:0] != 2'b00) |=> rdData == '0);
  a_r9_edge_port: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(7'h24)) |=> irqEdgeMask == $past(busWdata));
  a_r9_pol_port: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(7'h2C)) |=> irqPolMask == $past(busWdata));
  a_r9_cfgmap_port: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(7'h18)) |=> cfgMapWord == $past(busWdata));
endmodule

bind bridge_ctrl_regs bridge_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWr       (busWr),
  .busRd       (busRd),
  .busWdata    (busWdata),
  .rdData      (rdData),
  .rdValid     (rdValid),
  .softResetReq(softResetReq),
  .irqEdgeMask (irqEdgeMask),
  .irqPolMask  (irqPolMask),
  .cfgMapWord  (cfgMapWord),
  .enWord      (enWord)
);

// File: tb/tb_bridge_ctrl_regs.sv
module tb_bridge_ctrl_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        softResetReq;
  logic [31:0] irqEdgeMask;
  logic [31:0] irqPolMask;
  logic [31:0] cfgMapWord;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [31:0] expData;
    logic [6:0]  addr;
    string       tag;
  } rd_item_t;
  rd_item_t expQ[$];

  logic [31:0] model [28];

  always #5 clk = ~clk;

  bridge_ctrl_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .rdData(rdData), .rdValid(rdValid),
    .softResetReq(softResetReq), .irqEdgeMask(irqEdgeMask),
    .irqPolMask(irqPolMask), .cfgMapWord(cfgMapWord)
  );

  function automatic logic [31:0] expReset(int i);
    case (i * 4)
      'h00: return 32'h0000_0C40;
      'h04: return 32'h0000_1384;
      'h08: return 32'h2BFF_8010;
      'h0C: return 32'h255E_0091;
      'h10: return 32'h0000_6140;
      'h1C: return 32'h0000_01FF;
      'h20: return 32'h0000_01FF;
      'h68: return 32'h0000_0008;
      'h6C: return 32'h1000_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(logic [6:0] a);
    if (a[1:0] != 2'b00 || int'(a[6:2]) >= 28) return 32'h0;
    return model[a[6:2]];
  endfunction

  function automatic logic modelWrite(logic [6:0] a, logic [31:0] d);
    int i;
    logic pulse;
    pulse = 1'b0;
    if (a[1:0] != 2'b00 || int'(a[6:2]) >= 28) return 1'b0;
    i = int'(a[6:2]);
    case (i)
      12: begin model[12] = d; model[14] = model[14] | d; end
      13: begin model[13] = d; model[14] = model[14] & ~d; end
      14, 15: ;
      default: begin
        if (i == 1) pulse = !model[1][2] && d[2];
        model[i] = d;
      end
    endcase
    return pulse;
  endfunction

  task automatic checkPorts(string tag);
    check({tag, " R9 edge port"}, irqEdgeMask, model[9]);
    check({tag, " R9 pol port"}, irqPolMask, model[11]);
    check({tag, " R9 cfgmap port"}, cfgMapWord, model[6]);
  endtask

  task automatic doWrite(logic [6:0] a, logic [31:0] d);
    logic pulse;
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    pulse = modelWrite(a, d);
    @(negedge clk);
    busWr = 1'b0;
    check($sformatf("R6 pulse after write 0x%02h", a), {31'h0, softResetReq}, {31'h0, pulse});
    checkPorts("after write");
    if (pulse) begin
      @(negedge clk);
      check("R6 pulse lasts one cycle", {31'h0, softResetReq}, 32'h0);
    end
  endtask

  task automatic doRead(logic [6:0] a, string tag);
    rd_item_t it;
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    it.expData = modelRead(a); it.addr = a; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic doReadWrite(logic [6:0] a, logic [31:0] d);
    rd_item_t it;
    logic pulse;
    @(negedge clk);
    busAddr = a; busRd = 1'b1; busWr = 1'b1; busWdata = d;
    it.expData = modelRead(a); it.addr = a; it.tag = "R10 read-during-write old value";
    expQ.push_back(it);
    pulse = modelWrite(a, d);
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
  endtask

  // monitor: pop and compare as read results appear
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected rdValid", 32'h1, 32'h0);
      end else begin
        rd_item_t it;
        it = expQ.pop_front();
        check($sformatf("%s addr 0x%02h", it.tag, it.addr), rdData, it.expData);
      end
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    for (int i = 0; i < 28; i++) model[i] = expReset(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset softResetReq", {31'h0, softResetReq}, 32'h0);
    check("R1 reset rdValid", {31'h0, rdValid}, 32'h0);
    checkPorts("R1 reset");
    for (int i = 0; i < 28; i++) doRead(7'(i * 4), "R1 reset word");

    // R2 plain storage
    doWrite(7'h00, 32'hDEAD_BEEF);
    doWrite(7'h40, 32'h1111_2222);
    doWrite(7'h4C, 32'hA5A5_5A5A);
    doWrite(7'h60, 32'h0000_0001);
    doWrite(7'h6C, 32'hFFFF_FFFF);
    doRead(7'h00, "R2 plain word");
    doRead(7'h40, "R2 plain word");
    doRead(7'h4C, "R2 plain word");
    doRead(7'h60, "R2 plain word");
    doRead(7'h6C, "R2 plain word");

    // R9 exported words
    doWrite(7'h24, 32'h0000_00F3);
    doWrite(7'h2C, 32'h8000_0010);
    doWrite(7'h18, 32'h0001_2345);
    doRead(7'h24, "R9 edge word readback");

    // R3 / R4 set and clear aliases
    doWrite(7'h30, 32'h0000_00F0);
    doRead(7'h38, "R3 enable after set");
    doWrite(7'h30, 32'h0000_0F00);
    doRead(7'h38, "R3 enable after second set");
    doRead(7'h30, "R3 set word stored");
    doWrite(7'h34, 32'h0000_0130);
    doRead(7'h38, "R4 enable after clear");
    doRead(7'h34, "R4 clear word stored");

    // R5 read-only words
    doWrite(7'h38, 32'hFFFF_FFFF);
    doRead(7'h38, "R5 enable unchanged");
    doWrite(7'h3C, 32'h1234_5678);
    doRead(7'h3C, "R5 status reads zero");

    // R6 soft reset edge: reset value already has bit 2 set
    doWrite(7'h04, 32'h0000_1384);
    doWrite(7'h04, 32'h0000_1380);
    doRead(7'h04, "R6 value stored without pulse");
    doWrite(7'h04, 32'h0000_0004);
    doWrite(7'h04, 32'h0000_0004);
    doRead(7'h04, "R6 value stored");

    // R7 out-of-map and R8 misaligned
    doWrite(7'h70, 32'hCAFE_0001);
    doWrite(7'h7C, 32'hCAFE_0002);
    doRead(7'h70, "R7 unmapped read zero");
    doRead(7'h7C, "R7 unmapped read zero");
    for (int i = 0; i < 28; i++) doRead(7'(i * 4), "R7 map untouched");
    doWrite(7'h41, 32'h7777_7777);
    doWrite(7'h26, 32'h7777_7777);
    doRead(7'h40, "R8 misaligned write dropped");
    doRead(7'h24, "R8 misaligned write dropped");
    doRead(7'h41, "R8 misaligned read zero");

    // R10 simultaneous read and write
    doReadWrite(7'h50, 32'h0BAD_F00D);
    doRead(7'h50, "R10 new value after write");

    repeat (4) @(negedge clk);
    check("R2 all reads returned", 32'(expQ.size()), 32'h0);
    report();
    $finish;
  end
endmodule